// File: doc/BRIEF.md
# Thirty-two pin I/O bank with event interrupts

This block is one bank of general-purpose I/O pins with a 32-bit register interface on a simple word-addressed bus. Software decides, pin by pin, whether a pin is an input or is driven from an output latch. The latch can be written whole, or changed bit by bit through atomic set and clear aliases. Input levels pass through a two-flop synchroniser. The synchronised value feeds both the data-in register and the event detectors.

Each pin has four independent event sources: low level, high level, rising edge and falling edge. Any mix of them may be enabled on the same pin. One event vector feeds two separate latched status registers, one for each interrupt line. Each line has its own write-one enable set and clear registers and its own write-one-to-clear status. Each interrupt output goes high when any latched event is enabled for that line.

A read strobe returns the addressed register on `bus_rdata` one clock later. At all other times `bus_rdata` is zero. Addresses are byte offsets, and the low two bits are ignored.

Top module: `gpio_evt_bank`

## Requirements
- R1: Offset 0x000 reads the constant 0x50600801. Unmapped offsets (for example 0x004) read zero, and writes to them change nothing.
- R2: The direction register at 0x134 resets to all ones and can be read and written. A 1 in bit n makes pin n an input, and 0 makes it an output. `pin_dir` always shows this register.
- R3: The output latch at 0x13C resets to zero, can be read and written, and drives `pin_out`.
- R4: A write to 0x194 sets the latch bits where the written data is 1. A write to 0x190 clears the latch bits where the written data is 1. Zero bits leave the latch unchanged.
- R5: Offset 0x138 returns the input levels after a two-flop synchroniser, so a pin change becomes readable two clocks after it is sampled.
- R6: Four read/write detect-enable registers control events, with bit n belonging to pin n: low level at 0x140, high level at 0x144, rising edge at 0x148 and falling edge at 0x14C. Several may be enabled on one pin, and each of them raises an event on its own.
- R7: Raw status at 0x024 (line A) and 0x028 (line B) latches every detected event, whatever the line enables are.
- R8: Line enables are set by writing ones to 0x034 (A) or 0x038 (B) and cleared by writing ones to 0x03C (A) or 0x040 (B). Zero bits have no effect. Reading a set or clear offset returns that line's enable mask.
- R9: Masked status at 0x02C (A) and 0x030 (B) reads raw status AND that line's enables. Writing 1 to a bit there clears that line's latched bit only. Writing 0 has no effect.
- R10: A level event sets its bit again while the level persists, even straight after a clear, because a new event beats a clear in the same cycle. An edge event stays latched until it is cleared and does not return on its own.
- R11: `irq_a` is high exactly when some latched line-A event is enabled for line A, and `irq_b` likewise for line B. An interrupt line can only fall after a bus write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_rd | input | 1 | Read strobe |
| bus_wr | input | 1 | Write strobe |
| bus_addr | input | 9 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid the cycle after `bus_rd` |
| pin_in | input | 32 | Pin input levels, asynchronous |
| pin_out | output | 32 | Output latch |
| pin_dir | output | 32 | Direction, 1 means input |
| irq_a | output | 1 | Interrupt line A |
| irq_b | output | 1 | Interrupt line B |

## Verification
The bus properties assume that read and write strobes are never raised together and that addresses are word aligned. The bench's tasks raise one strobe at a time, always with aligned offsets. The interrupt-fall property assumes that only bus writes remove enables or latched events, so `bus_wr` is held low through reset. Pin inputs change only on falling clock edges, and each change is followed by several idle clocks before a read, so the synchroniser latency is always covered.

// File: rtl/gpio_evt_bank.sv
module gpio_evt_bank #(
  parameter int N_PINS = 32,
  parameter int AW = 9,
  parameter logic [31:0] REV_ID = 32'h5060_0801
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_rd,
  input  logic              bus_wr,
  input  logic [AW-1:0]     bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  input  logic [N_PINS-1:0] pin_in,
  output logic [N_PINS-1:0] pin_out,
  output logic [N_PINS-1:0] pin_dir,
  output logic              irq_a,
  output logic              irq_b
);
  localparam int WW = AW - 2;
  localparam logic [WW-1:0] W_REV   = WW'(9'h000 >> 2);
  localparam logic [WW-1:0] W_RAWA  = WW'(9'h024 >> 2);
  localparam logic [WW-1:0] W_RAWB  = WW'(9'h028 >> 2);
  localparam logic [WW-1:0] W_STA   = WW'(9'h02C >> 2);
  localparam logic [WW-1:0] W_STB   = WW'(9'h030 >> 2);
  localparam logic [WW-1:0] W_ENSA  = WW'(9'h034 >> 2);
  localparam logic [WW-1:0] W_ENSB  = WW'(9'h038 >> 2);
  localparam logic [WW-1:0] W_ENCA  = WW'(9'h03C >> 2);
  localparam logic [WW-1:0] W_ENCB  = WW'(9'h040 >> 2);
  localparam logic [WW-1:0] W_DIR   = WW'(9'h134 >> 2);
  localparam logic [WW-1:0] W_DIN   = WW'(9'h138 >> 2);
  localparam logic [WW-1:0] W_DOUT  = WW'(9'h13C >> 2);
  localparam logic [WW-1:0] W_LVLO  = WW'(9'h140 >> 2);
  localparam logic [WW-1:0] W_LVHI  = WW'(9'h144 >> 2);
  localparam logic [WW-1:0] W_RISE  = WW'(9'h148 >> 2);
  localparam logic [WW-1:0] W_FALL  = WW'(9'h14C >> 2);
  localparam logic [WW-1:0] W_OCLR  = WW'(9'h190 >> 2);
  localparam logic [WW-1:0] W_OSET  = WW'(9'h194 >> 2);

  logic [WW-1:0]     wa;
  logic [N_PINS-1:0] wd;
  logic [N_PINS-1:0] sync1, sync2, prev;
  logic [N_PINS-1:0] dir_q, out_q, lvlo_q, lvhi_q, rise_q, fall_q;
  logic [N_PINS-1:0] en_a, en_b, raw_a, raw_b, evt;
  logic [N_PINS-1:0] clr_a, clr_b;
  logic [31:0]       rmux;

  assign wa = bus_addr[AW-1:2];
  assign wd = bus_wdata[N_PINS-1:0];

  assign evt = (lvlo_q & ~sync2) | (lvhi_q & sync2)
             | (rise_q & sync2 & ~prev) | (fall_q & ~sync2 & prev);

  assign clr_a = (bus_wr && wa == W_STA) ? wd : '0;
  assign clr_b = (bus_wr && wa == W_STB) ? wd : '0;

  assign pin_out = out_q;
  assign pin_dir = dir_q;
  assign irq_a   = |(raw_a & en_a);
  assign irq_b   = |(raw_b & en_b);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sync1 <= '0;
      sync2 <= '0;
      prev  <= '0;
      raw_a <= '0;
      raw_b <= '0;
    end else begin
      sync1 <= pin_in;
      sync2 <= sync1;
      prev  <= sync2;
      raw_a <= (raw_a & ~clr_a) | evt;
      raw_b <= (raw_b & ~clr_b) | evt;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      dir_q  <= '1;
      out_q  <= '0;
      lvlo_q <= '0;
      lvhi_q <= '0;
      rise_q <= '0;
      fall_q <= '0;
      en_a   <= '0;
      en_b   <= '0;
    end else if (bus_wr) begin
      case (wa)
        W_DIR:  dir_q  <= wd;
        W_DOUT: out_q  <= wd;
        W_OSET: out_q  <= out_q | wd;
        W_OCLR: out_q  <= out_q & ~wd;
        W_LVLO: lvlo_q <= wd;
        W_LVHI: lvhi_q <= wd;
        W_RISE: rise_q <= wd;
        W_FALL: fall_q <= wd;
        W_ENSA: en_a   <= en_a | wd;
        W_ENSB: en_b   <= en_b | wd;
        W_ENCA: en_a   <= en_a & ~wd;
        W_ENCB: en_b   <= en_b & ~wd;
        default: ;
      endcase
    end
  end

  always_comb begin
    rmux = '0;
    case (wa)
      W_REV:          rmux = REV_ID;
      W_RAWA:         rmux = 32'(raw_a);
      W_RAWB:         rmux = 32'(raw_b);
      W_STA:          rmux = 32'(raw_a & en_a);
      W_STB:          rmux = 32'(raw_b & en_b);
      W_ENSA, W_ENCA: rmux = 32'(en_a);
      W_ENSB, W_ENCB: rmux = 32'(en_b);
      W_DIR:          rmux = 32'(dir_q);
      W_DIN:          rmux = 32'(sync2);
      W_DOUT:         rmux = 32'(out_q);
      W_LVLO:         rmux = 32'(lvlo_q);
      W_LVHI:         rmux = 32'(lvhi_q);
      W_RISE:         rmux = 32'(rise_q);
      W_FALL:         rmux = 32'(fall_q);
      default:        rmux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) bus_rdata <= '0;
    else        bus_rdata <= bus_rd ? rmux : '0;
  end
endmodule

// File: rtl/gpio_evt_bank_chk.sv
module gpio_evt_bank_chk #(
  parameter int N_PINS = 32,
  parameter int AW = 9
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bus_rd,
  input logic              bus_wr,
  input logic [AW-1:0]     bus_addr,
  input logic [31:0]       bus_wdata,
  input logic [31:0]       bus_rdata,
  input logic [N_PINS-1:0] pin_out,
  input logic [N_PINS-1:0] pin_dir,
  input logic              irq_a,
  input logic              irq_b
);
  assert_rev_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && bus_addr == AW'(9'h000)) |=> bus_rdata == 32'h5060_0801);

  assert_unmapped_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && bus_addr == AW'(9'h004)) |=> bus_rdata == 32'h0);

  assert_dir_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == AW'(9'h134)) |=> pin_dir == $past(bus_wdata[N_PINS-1:0]));

  assert_out_set_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == AW'(9'h194)) |=>
      (pin_out & $past(bus_wdata[N_PINS-1:0])) == $past(bus_wdata[N_PINS-1:0]));

  assert_out_clr_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == AW'(9'h190)) |=>
      (pin_out & $past(bus_wdata[N_PINS-1:0])) == '0);

  assert_irqa_fall_R11: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(irq_a) |-> $past(bus_wr));

  assert_irqb_fall_R11: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(irq_b) |-> $past(bus_wr));
endmodule

bind gpio_evt_bank gpio_evt_bank_chk #(.N_PINS(N_PINS), .AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_rd(bus_rd), .bus_wr(bus_wr),
  .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
  .pin_out(pin_out), .pin_dir(pin_dir), .irq_a(irq_a), .irq_b(irq_b)
);

// File: tb/gpio_evt_bank_bench.sv
module gpio_evt_bank_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_rd = 1'b0;
  logic        bus_wr = 1'b0;
  logic [8:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [31:0] pin_in = '0;
  logic [31:0] pin_out, pin_dir;
  logic        irq_a, irq_b;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  typedef struct {
    logic [31:0] exp;
    string       tag;
  } item_t;
  item_t sb[$];

  always #4 clk = ~clk;

  gpio_evt_bank u_gpio_evt_bank (
    .clk(clk), .rst_n(rst_n), .bus_rd(bus_rd), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .pin_in(pin_in), .pin_out(pin_out), .pin_dir(pin_dir),
    .irq_a(irq_a), .irq_b(irq_b)
  );

  always @(posedge clk) begin
    #2;
    if (bus_rd) begin
      item_t it;
      it = sb.pop_front();
      checks++;
      if (bus_rdata !== it.exp) begin
        errors++;
        $display("FAIL %s: read got %h expected %h", it.tag, bus_rdata, it.exp);
      end
    end
  end

  task automatic wr(input logic [8:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [8:0] a, input logic [31:0] e, input string tag);
    item_t it;
    it.exp = e; it.tag = tag;
    @(negedge clk);
    sb.push_back(it);
    bus_rd = 1'b1; bus_addr = a;
    @(negedge clk);
    bus_rd = 1'b0;
  endtask

  task automatic chk(input logic [31:0] act, input logic [31:0] e, input string tag);
    checks++;
    if (act !== e) begin
      errors++;
      $display("FAIL %s: got %h expected %h", tag, act, e);
    end
  endtask

  task automatic pins(input logic [31:0] v);
    @(negedge clk);
    pin_in = v;
    repeat (4) @(negedge clk);
  endtask

  task automatic finish_up();
    if (!done) begin
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    #(8 * 200000);
    checks++; errors++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_up();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(pin_dir, 32'hFFFF_FFFF, "R2 reset direction");
    chk(pin_out, 32'h0, "R3 reset latch");
    chk({31'h0, irq_a}, 32'h0, "R11 reset irq_a");
    chk({31'h0, irq_b}, 32'h0, "R11 reset irq_b");

    rd(9'h000, 32'h5060_0801, "R1 revision");
    rd(9'h134, 32'hFFFF_FFFF, "R2 direction readback");
    rd(9'h004, 32'h0, "R1 unmapped read");
    wr(9'h004, 32'hDEAD_BEEF);
    rd(9'h004, 32'h0, "R1 unmapped write ignored");

    wr(9'h134, 32'hFFFF_0000);
    chk(pin_dir, 32'hFFFF_0000, "R2 direction write");
    wr(9'h13C, 32'h0000_A5A5);
    chk(pin_out, 32'h0000_A5A5, "R3 latch drive");
    rd(9'h13C, 32'h0000_A5A5, "R3 latch readback");
    wr(9'h194, 32'h0000_0F00);
    chk(pin_out, 32'h0000_AFA5, "R4 set alias");
    wr(9'h190, 32'h0000_00A5);
    chk(pin_out, 32'h0000_AF00, "R4 clear alias");
    rd(9'h13C, 32'h0000_AF00, "R4 latch after aliases");

    pins(32'h1234_5678);
    rd(9'h138, 32'h1234_5678, "R5 data in");
    pins(32'h0);
    rd(9'h138, 32'h0, "R5 data in low");

    wr(9'h140, 32'h8);
    rd(9'h024, 32'h8, "R6 R7 low level raw A");
    rd(9'h028, 32'h8, "R7 low level raw B");
    rd(9'h02C, 32'h0, "R9 masked with no enables");

    wr(9'h034, 32'hF);
    rd(9'h034, 32'hF, "R8 enable A set");
    rd(9'h038, 32'h0, "R8 enable B untouched");
    chk({31'h0, irq_a}, 32'h1, "R11 irq_a on");
    chk({31'h0, irq_b}, 32'h0, "R11 irq_b off");
    rd(9'h02C, 32'h8, "R9 masked A");

    wr(9'h02C, 32'h8);
    rd(9'h024, 32'h8, "R10 level reasserts after clear");

    pins(32'h8);
    wr(9'h02C, 32'h8);
    rd(9'h024, 32'h0, "R9 clear A");
    rd(9'h028, 32'h8, "R9 line B independent");
    chk({31'h0, irq_a}, 32'h0, "R11 irq_a off after clear");
    wr(9'h030, 32'h0);
    rd(9'h028, 32'h8, "R9 zero write no effect");
    wr(9'h030, 32'h8);
    rd(9'h028, 32'h0, "R9 clear B");

    wr(9'h148, 32'h1);
    pins(32'h9);
    rd(9'h024, 32'h1, "R6 rising edge");
    pins(32'h8);
    rd(9'h024, 32'h1, "R10 edge stays latched");
    chk({31'h0, irq_a}, 32'h1, "R11 irq_a on edge");
    wr(9'h02C, 32'h1);
    rd(9'h024, 32'h0, "R10 edge does not return");

    wr(9'h14C, 32'h2);
    wr(9'h148, 32'h3);
    pins(32'hA);
    rd(9'h024, 32'h2, "R6 combined rise");
    wr(9'h02C, 32'h2);
    rd(9'h024, 32'h0, "R9 clear rise");
    pins(32'h8);
    rd(9'h024, 32'h2, "R6 combined fall");
    wr(9'h02C, 32'h2);
    rd(9'h024, 32'h0, "R9 clear fall");

    wr(9'h144, 32'h4);
    pins(32'hC);
    rd(9'h024, 32'h4, "R6 high level");
    rd(9'h140, 32'h8, "R6 low readback");
    rd(9'h144, 32'h4, "R6 high readback");
    rd(9'h148, 32'h3, "R6 rise readback");
    rd(9'h14C, 32'h2, "R6 fall readback");

    wr(9'h03C, 32'hF);
    rd(9'h034, 32'h0, "R8 enable A cleared");
    chk({31'h0, irq_a}, 32'h0, "R11 irq_a masked");
    wr(9'h038, 32'h4);
    chk({31'h0, irq_b}, 32'h1, "R11 irq_b on");
    rd(9'h040, 32'h4, "R8 clear offset reads mask");
    wr(9'h030, 32'h4);
    rd(9'h030, 32'h4, "R10 event beats clear");
    rd(9'h028, 32'h7, "R7 raw B accumulates");

    repeat (2) @(negedge clk);
    finish_up();
  end
endmodule